// File: doc/BRIEF.md
# Four-Operand Arithmetic-Logic Unit with Status Flags

This block is the execution unit of a small teaching processor. It holds four 8-bit unsigned general registers, named A, B, C and D, which are filled through a simple load port. Four operand ports feed the arithmetic logic. Each port has its own 2-bit selector, so any register can drive any port, and one register may drive several ports at once. Each function reads a fixed subset of these ports.

A 5-bit operation code picks one of seventeen functions:
- bitwise logic and one-place rotates;
- one's and two's complement;
- logical AND and OR;
- a three-way compare;
- a bit-field pack;
- binary add and subtract;
- binary-to-BCD conversion;
- BCD add and subtract.

On every falling clock edge the unit reads the selected registers and captures a 12-bit result and a 3-bit status word. Each function updates only the flags that belong to it and clears the others. Codes above the defined range hold both output registers.

Top module: `quad_alu`

## Requirements
- R1: A synchronous active-high reset clears the four general registers (on the rising edge), and clears the result and status registers (on the falling edge).
- R2: When `ld_en` is high at a rising clock edge, `ld_data` is written to the register picked by `ld_sel`. For `ld_sel` and for every operand selector, the value 0 picks A, 1 picks B, 2 picks C and 3 picks D. Ports 1 to 4 are selected independently of each other.
- R3: `result` and `status` change only at falling clock edges, and a new operation code becomes visible after the next falling edge.
- R4: Codes 0 to 6 produce, in this order: ~(P1&P4), ~(P1|P4), P1^P4, P4 rotated right by one place, P4 rotated left by one place, ~P3, and the 8-bit two's complement of P3. Each 8-bit result is zero-extended to 12 bits.
- R5: Code 7 writes 1 when P1 and P2 are both nonzero, and 0 otherwise. Code 8 writes 1 when either of P1 or P2 is nonzero, and 0 otherwise.
- R6: Code 9 writes 0 when P2 > P4, 1 when P2 == P4, and 2 when P2 < P4.
- R7: Code 10 writes {P4[2:0], P2[2:0], P3[1:0]} into result bits 7:0 and zero into bits 11:8.
- R8: Code 11 writes the 9-bit sum P1+P3. C equals sum bit 8. V is set when P1 and P3, read as signed 8-bit values, give a sum outside the range -128 to 127.
- R9: Code 12 writes the 8-bit difference P1-P3, taken modulo 256. V is the signed 8-bit overflow of the subtraction, and C stays 0.
- R10: Codes 13 and 14 write P2 and P3 respectively as three BCD digits, with hundreds in bits 11:8, tens in bits 7:4 and units in bits 3:0.
- R11: Code 15 writes the three-digit BCD form of P2+P3. C is set when (P2 mod 100) + (P3 mod 100) is 100 or more.
- R12: Code 16 handles BCD subtraction. When P2 >= P3 it writes the BCD form of P2-P3 with V=0. Otherwise it writes the BCD form of 1000-(P3-P2) with V=1.
- R13: Status bit 2 is C, bit 1 is Z and bit 0 is V. For every code from 0 to 16, Z is 1 exactly when the new result is zero. C is set only by codes 11 and 15, and V only by codes 11, 12 and 16. In all other cases each flag is written as 0.
- R14: Codes 17 to 31 leave `result` and `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The load port acts on the rising edge and the outputs update on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 2 | Register to load (0=A, 1=B, 2=C, 3=D) |
| ld_data | input | 8 | Value to load |
| op1_sel | input | 2 | Register driving operand port 1 |
| op2_sel | input | 2 | Register driving operand port 2 |
| op3_sel | input | 2 | Register driving operand port 3 |
| op4_sel | input | 2 | Register driving operand port 4 |
| opcode | input | 5 | Function select |
| result | output | 12 | Result register |
| status | output | 3 | Status register {C, Z, V} |

## Verification
The bench sweeps 256 register fills drawn from values near the edges, among them 0, 0x7F, 0x80, 0xFF, 99 and 100. It runs every code under rotating selector patterns, so that a selector wired to the wrong port or register shows up as a wrong operand.

Operand pairs near the signed boundary catch an overflow computed from unsigned or carry bits. Pairs whose low two decimal digits cross 100 catch a BCD carry taken from the binary carry instead. Operands with P2 < P3 catch a BCD subtract that fails to wrap to the ten's complement or to raise V.

Reserved codes are issued after valid ones, which exposes a design that clears or recomputes its outputs instead of holding them. A sample taken between the rising edge and the falling edge catches outputs clocked on the wrong edge.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;

    localparam int DATA_W = 8;
    localparam int RES_W  = 12;
    localparam int NREG   = 4;
    localparam int NPORT  = 4;
    localparam int OP_W   = 5;
    localparam int BIN_W  = 10;
    localparam int DIGITS = RES_W / 4;

    typedef enum logic [OP_W-1:0] {
        OP_NAND = 5'd0,
        OP_NOR  = 5'd1,
        OP_XOR  = 5'd2,
        OP_ROR  = 5'd3,
        OP_ROL  = 5'd4,
        OP_INV  = 5'd5,
        OP_NEG  = 5'd6,
        OP_LAND = 5'd7,
        OP_LOR  = 5'd8,
        OP_CMP  = 5'd9,
        OP_CAT  = 5'd10,
        OP_ADD  = 5'd11,
        OP_SUB  = 5'd12,
        OP_BCD2 = 5'd13,
        OP_BCD3 = 5'd14,
        OP_BADD = 5'd15,
        OP_BSUB = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic v;
    } alu_flags_t;

    // Shift-and-add-three conversion of a binary value into packed decimal digits.
    function automatic logic [RES_W-1:0] bin_to_bcd(input logic [BIN_W-1:0] bin);
        logic [RES_W+BIN_W-1:0] sr;
        sr = {{RES_W{1'b0}}, bin};
        for (int i = 0; i < BIN_W; i++) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (sr[BIN_W+4*d +: 4] > 4'd4)
                    sr[BIN_W+4*d +: 4] = sr[BIN_W+4*d +: 4] + 4'd3;
            end
            sr = sr << 1;
        end
        return sr[RES_W+BIN_W-1 -: RES_W];
    endfunction

endpackage

// File: rtl/quad_alu_regfile.sv
module quad_alu_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_en,
    input  logic [SEL_W-1:0]             ld_sel,
    input  logic [DATA_W-1:0]            ld_data,
    output logic [NREG-1:0][DATA_W-1:0]  regs
);

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (rst)
                regs[r] <= '0;
            else if (ld_en && (ld_sel == SEL_W'(r)))
                regs[r] <= ld_data;
        end
    end

endmodule

// File: rtl/quad_alu_operand_sel.sv
module quad_alu_operand_sel #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    parameter int NPORT  = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][DATA_W-1:0]   regs,
    input  logic [NPORT-1:0][SEL_W-1:0]   sels,
    output logic [NPORT-1:0][DATA_W-1:0]  opnd
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign opnd[p] = regs[sels[p]];
    end

endmodule

// File: rtl/quad_alu_bcd.sv
module quad_alu_bcd
    import quad_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [RES_W-1:0] a_bcd,
    output logic [RES_W-1:0] b_bcd,
    output logic [RES_W-1:0] sum_bcd,
    output logic             sum_carry,
    output logic [RES_W-1:0] diff_bcd,
    output logic             diff_borrow
);

    logic [W:0]       sum_bin;
    logic [W-1:0]     a_lo, b_lo;
    logic [W:0]       lo_sum;
    logic [W-1:0]     mag;
    logic [BIN_W-1:0] diff_bin;

    assign a_bcd   = bin_to_bcd(BIN_W'(a));
    assign b_bcd   = bin_to_bcd(BIN_W'(b));

    assign sum_bin = {1'b0, a} + {1'b0, b};
    assign sum_bcd = bin_to_bcd(BIN_W'(sum_bin));

    // Carry out of the two low decimal digits.
    assign a_lo      = a % W'(100);
    assign b_lo      = b % W'(100);
    assign lo_sum    = {1'b0, a_lo} + {1'b0, b_lo};
    assign sum_carry = (lo_sum >= (W+1)'(100));

    // Ten's complement over three digits when the subtrahend is larger.
    assign diff_borrow = (a < b);
    assign mag         = diff_borrow ? (b - a) : (a - b);
    assign diff_bin    = diff_borrow ? (BIN_W'(1000) - BIN_W'(mag)) : BIN_W'(mag);
    assign diff_bcd    = bin_to_bcd(diff_bin);

endmodule

// File: rtl/quad_alu_core.sv
module quad_alu_core
    import quad_alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NP    = NPORT
) (
    input  logic [OP_W-1:0]         opcode,
    input  logic [NP-1:0][W-1:0]    opnd,
    input  logic [RES_W-1:0]        p2_bcd,
    input  logic [RES_W-1:0]        p3_bcd,
    input  logic [RES_W-1:0]        bsum,
    input  logic                    bsum_carry,
    input  logic [RES_W-1:0]        bdiff,
    input  logic                    bdiff_borrow,
    output logic [RES_W-1:0]        nxt_res,
    output alu_flags_t              nxt_flags,
    output logic                    live
);

    logic [W-1:0] p1, p2, p3, p4;
    logic [W:0]   sum_w;
    logic [W-1:0] diff_w;
    logic [W-1:0] neg_w;

    assign p1 = opnd[0];
    assign p2 = opnd[1];
    assign p3 = opnd[2];
    assign p4 = opnd[3];

    assign sum_w  = {1'b0, p1} + {1'b0, p3};
    assign diff_w = p1 - p3;
    assign neg_w  = ~p3 + W'(1);

    function automatic logic [RES_W-1:0] widen(input logic [W-1:0] x);
        return {{(RES_W-W){1'b0}}, x};
    endfunction

    always_comb begin
        nxt_res   = '0;
        nxt_flags = '0;
        live      = 1'b1;
        case (opcode)
            OP_NAND: nxt_res = widen(~(p1 & p4));
            OP_NOR:  nxt_res = widen(~(p1 | p4));
            OP_XOR:  nxt_res = widen(p1 ^ p4);
            OP_ROR:  nxt_res = widen({p4[0], p4[W-1:1]});
            OP_ROL:  nxt_res = widen({p4[W-2:0], p4[W-1]});
            OP_INV:  nxt_res = widen(~p3);
            OP_NEG:  nxt_res = widen(neg_w);
            OP_LAND: nxt_res = RES_W'((p1 != '0) && (p2 != '0));
            OP_LOR:  nxt_res = RES_W'((p1 != '0) || (p2 != '0));
            OP_CMP: begin
                if (p2 > p4)       nxt_res = RES_W'(0);
                else if (p2 == p4) nxt_res = RES_W'(1);
                else               nxt_res = RES_W'(2);
            end
            OP_CAT:  nxt_res = RES_W'({p4[2:0], p2[2:0], p3[1:0]});
            OP_ADD: begin
                nxt_res     = RES_W'(sum_w);
                nxt_flags.c = sum_w[W];
                nxt_flags.v = (p1[W-1] == p3[W-1]) && (sum_w[W-1] != p1[W-1]);
            end
            OP_SUB: begin
                nxt_res     = widen(diff_w);
                nxt_flags.v = (p1[W-1] != p3[W-1]) && (diff_w[W-1] != p1[W-1]);
            end
            OP_BCD2: nxt_res = p2_bcd;
            OP_BCD3: nxt_res = p3_bcd;
            OP_BADD: begin
                nxt_res     = bsum;
                nxt_flags.c = bsum_carry;
            end
            OP_BSUB: begin
                nxt_res     = bdiff;
                nxt_flags.v = bdiff_borrow;
            end
            default: live = 1'b0;
        endcase
        nxt_flags.z = live && (nxt_res == '0);
    end

endmodule

// File: rtl/quad_alu.sv
module quad_alu
    import quad_alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NR    = NREG,
    localparam int SEL_W = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [W-1:0]     ld_data,
    input  logic [SEL_W-1:0] op1_sel,
    input  logic [SEL_W-1:0] op2_sel,
    input  logic [SEL_W-1:0] op3_sel,
    input  logic [SEL_W-1:0] op4_sel,
    input  logic [OP_W-1:0]  opcode,
    output logic [RES_W-1:0] result,
    output logic [2:0]       status
);

    logic [NR-1:0][W-1:0]        regs;
    logic [NPORT-1:0][SEL_W-1:0] sel_bus;
    logic [NPORT-1:0][W-1:0]     opnd;
    logic [RES_W-1:0]            p2_bcd, p3_bcd, bsum, bdiff;
    logic                        bsum_carry, bdiff_borrow;
    logic [RES_W-1:0]            nxt_res;
    alu_flags_t                  nxt_flags;
    logic                        live;
    alu_flags_t                  flags_q;

    assign sel_bus = {op4_sel, op3_sel, op2_sel, op1_sel};

    quad_alu_regfile #(.DATA_W(W), .NREG(NR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .regs    (regs)
    );

    quad_alu_operand_sel #(.DATA_W(W), .NREG(NR), .NPORT(NPORT)) u_sel (
        .regs (regs),
        .sels (sel_bus),
        .opnd (opnd)
    );

    quad_alu_bcd #(.W(W)) u_bcd (
        .a           (opnd[1]),
        .b           (opnd[2]),
        .a_bcd       (p2_bcd),
        .b_bcd       (p3_bcd),
        .sum_bcd     (bsum),
        .sum_carry   (bsum_carry),
        .diff_bcd    (bdiff),
        .diff_borrow (bdiff_borrow)
    );

    quad_alu_core #(.W(W), .NP(NPORT)) u_core (
        .opcode       (opcode),
        .opnd         (opnd),
        .p2_bcd       (p2_bcd),
        .p3_bcd       (p3_bcd),
        .bsum         (bsum),
        .bsum_carry   (bsum_carry),
        .bdiff        (bdiff),
        .bdiff_borrow (bdiff_borrow),
        .nxt_res      (nxt_res),
        .nxt_flags    (nxt_flags),
        .live         (live)
    );

    always_ff @(negedge clk) begin
        if (rst) begin
            result  <= '0;
            flags_q <= '0;
        end else if (live) begin
            result  <= nxt_res;
            flags_q <= nxt_flags;
        end
    end

    assign status = flags_q;

endmodule

// File: rtl/quad_alu_checker.sv
module quad_alu_checker
    import quad_alu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OP_W-1:0]  opcode,
    input logic [RES_W-1:0] result,
    input logic [2:0]       status
);

    AST_RESERVED_HOLD: assert property (@(negedge clk) disable iff (rst)
        (opcode > OP_BSUB) |=> (result == $past(result) && status == $past(status)))
        else $error("reserved code altered outputs"); // R14

    AST_CMP_RANGE: assert property (@(negedge clk) disable iff (rst)
        (opcode == OP_CMP) |=> (result <= RES_W'(2)))
        else $error("compare result out of range"); // R6

    AST_LOGIC_BOOL: assert property (@(negedge clk) disable iff (rst)
        (opcode == OP_LAND || opcode == OP_LOR) |=> (result[RES_W-1:1] == '0))
        else $error("logical op result not 0/1"); // R5

    AST_CARRY_SCOPE: assert property (@(negedge clk) disable iff (rst)
        (opcode <= OP_BSUB && opcode != OP_ADD && opcode != OP_BADD) |=> !status[2])
        else $error("carry set by a non-add code"); // R13

    AST_OVF_SCOPE: assert property (@(negedge clk) disable iff (rst)
        (opcode <= OP_BSUB && opcode != OP_ADD && opcode != OP_SUB && opcode != OP_BSUB)
        |=> !status[0])
        else $error("overflow set by an unrelated code"); // R13

    AST_ZERO_MATCH: assert property (@(negedge clk) disable iff (rst)
        (opcode <= OP_BSUB) |=> (status[1] == (result == '0)))
        else $error("zero flag disagrees with result"); // R13

    AST_BCD_DIGITS: assert property (@(negedge clk) disable iff (rst)
        (opcode >= OP_BCD2 && opcode <= OP_BSUB)
        |=> (result[3:0] <= 4'd9 && result[7:4] <= 4'd9 && result[11:8] <= 4'd9))
        else $error("non-decimal digit in BCD result"); // R10

endmodule

bind quad_alu quad_alu_checker u_quad_alu_chk (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .result (result),
    .status (status)
);

// File: tb/quad_alu_bench.sv
module quad_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [1:0]  ld_sel;
    logic [7:0]  ld_data;
    logic [1:0]  op1_sel, op2_sel, op3_sel, op4_sel;
    logic [4:0]  opcode;
    logic [11:0] result;
    logic [2:0]  status;

    int n_cmp = 0;
    int n_bad = 0;
    int mreg [4];
    int exp_r = 0;
    int exp_s = 0;

    quad_alu u_quad_alu (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .op1_sel (op1_sel),
        .op2_sel (op2_sel),
        .op3_sel (op3_sel),
        .op4_sel (op4_sel),
        .opcode  (opcode),
        .result  (result),
        .status  (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int to_bcd(int n);
        return (n / 100) * 256 + ((n / 10) % 10) * 16 + (n % 10);
    endfunction

    function automatic int sgn(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string tag_of(int op);
        if (op <= 6)  return "R4 R13";
        if (op <= 8)  return "R5 R13";
        if (op == 9)  return "R6 R13";
        if (op == 10) return "R7 R13";
        if (op == 11) return "R8 R13";
        if (op == 12) return "R9 R13";
        if (op <= 14) return "R10 R13";
        if (op == 15) return "R11 R13";
        if (op == 16) return "R12 R13";
        return "R14";
    endfunction

    // Arithmetic reference for one operation; reserved codes leave r and st alone.
    task automatic model(input int op, input int o1, input int o2, input int o3, input int o4,
                         inout int r, inout int st);
        int res, c, v, s;
        c = 0; v = 0; res = 0;
        if (op > 16) return;
        case (op)
            0:  res = (~(o1 & o4)) & 255;
            1:  res = (~(o1 | o4)) & 255;
            2:  res = o1 ^ o4;
            3:  res = (o4 >> 1) | ((o4 & 1) << 7);
            4:  res = ((o4 << 1) & 255) | (o4 >> 7);
            5:  res = 255 - o3;
            6:  res = (256 - o3) & 255;
            7:  res = (o1 != 0 && o2 != 0) ? 1 : 0;
            8:  res = (o1 != 0 || o2 != 0) ? 1 : 0;
            9:  res = (o2 > o4) ? 0 : ((o2 == o4) ? 1 : 2);
            10: res = ((o4 & 7) << 5) | ((o2 & 7) << 2) | (o3 & 3);
            11: begin
                res = o1 + o3;
                c = (res > 255) ? 1 : 0;
                s = sgn(o1) + sgn(o3);
                v = (s > 127 || s < -128) ? 1 : 0;
            end
            12: begin
                res = (o1 - o3) & 255;
                s = sgn(o1) - sgn(o3);
                v = (s > 127 || s < -128) ? 1 : 0;
            end
            13: res = to_bcd(o2);
            14: res = to_bcd(o3);
            15: begin
                res = to_bcd(o2 + o3);
                c = ((o2 % 100) + (o3 % 100) >= 100) ? 1 : 0;
            end
            default: begin
                if (o2 >= o3) res = to_bcd(o2 - o3);
                else begin
                    res = to_bcd(1000 - (o3 - o2));
                    v = 1;
                end
            end
        endcase
        r  = res;
        st = c * 4 + ((res == 0) ? 2 : 0) + v;
    endtask

    task automatic check(input string tag, input int er, input int es);
        n_cmp++;
        if (result !== er[11:0] || status !== es[2:0]) begin
            n_bad++;
            $display("FAIL %s: result=%h status=%b expected result=%h status=%b",
                     tag, result, status, er[11:0], es[2:0]);
        end
    endtask

    task automatic load(input int idx, input int val);
        @(negedge clk);
        #1;
        ld_en   = 1'b1;
        ld_sel  = idx[1:0];
        ld_data = val[7:0];
        opcode  = 5'd31;
        @(posedge clk);
        #1;
        ld_en     = 1'b0;
        mreg[idx] = val;
    endtask

    task automatic do_op(input int op, input int s1, input int s2, input int s3, input int s4,
                         input string tag);
        @(negedge clk);
        #1;
        opcode  = op[4:0];
        op1_sel = s1[1:0];
        op2_sel = s2[1:0];
        op3_sel = s3[1:0];
        op4_sel = s4[1:0];
        @(negedge clk);
        #1;
        model(op, mreg[s1], mreg[s2], mreg[s3], mreg[s4], exp_r, exp_s);
        check((tag == "") ? tag_of(op) : tag, exp_r, exp_s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: result=%h status=%b expected completion", result, status);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int vals [16] = '{0, 1, 2, 7, 8, 9, 15, 53, 38, 99, 100, 127, 128, 129, 254, 255};
        rst = 1'b1; ld_en = 1'b0; ld_sel = '0; ld_data = '0;
        op1_sel = '0; op2_sel = '0; op3_sel = '0; op4_sel = '0; opcode = 5'd31;
        for (int k = 0; k < 4; k++) mreg[k] = 0;
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        check("R1", 0, 0);
        // R1: registers cleared, so A+A gives zero with Z set.
        do_op(11, 0, 0, 0, 0, "R1");

        load(0, 8'h35); load(1, 8'h26); load(2, 8'h63); load(3, 8'hFE);
        // R2: each register routed alone to port 2 through BCD conversion.
        for (int r = 0; r < 4; r++) do_op(13, 0, r, 0, 0, "R2");
        // R2: ports routed independently (P4 from D, P1 from B, P3 from C).
        do_op(2, 1, 0, 2, 3, "R2");

        // R3: outputs hold through the rising edge and change at the falling edge.
        @(negedge clk);
        #1;
        opcode = 5'd11; op1_sel = 2'd0; op3_sel = 2'd2;
        @(posedge clk);
        #1;
        check("R3", exp_r, exp_s);
        @(negedge clk);
        #1;
        model(11, mreg[0], mreg[1], mreg[2], mreg[3], exp_r, exp_s);
        check("R3", exp_r, exp_s);

        // R14: reserved code directly after a valid one.
        do_op(20, 0, 1, 2, 3, "R14");

        for (int c = 0; c < 256; c++) begin
            int i, j;
            i = c % 16;
            j = c / 16;
            load(0, vals[i]);
            load(1, vals[j]);
            load(2, vals[(i + 3 * j) % 16]);
            load(3, vals[(5 * i + j) % 16]);
            for (int op = 0; op <= 16; op++) begin
                do_op(op, (c + op) % 4, (c / 4 + op) % 4, (c / 16 + 2 * op) % 4,
                      (c + op / 2 + 3) % 4, "");
            end
            do_op(17 + (c % 15), c % 4, (c + 1) % 4, (c + 2) % 4, (c + 3) % 4, "R14");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule